// File: doc/BRIEF.md
# PIR Sensor Bring-up and Detection Sequencer

This block brings a passive-infrared motion sensor from power-off to detecting. It controls the sensor's supply enable and watches a single shared line. That line first carries the sensor's ready signalling, then serves as the settings clock while a separate settings engine drives it, and finally carries the detection output. Each bring-up has the same steps. The supply is turned off for a fixed minimum time and then turned back on. Edges on the line are ignored while the supply ramps up. The block then waits for exactly two falling edges, which mark readiness, and gives up if they do not arrive in time. After a short gap it starts the settings engine through a start/done handshake.

When the settings engine reports success, the block releases both sensor lines to input and enters detection mode. In detection mode a rising edge on the line becomes a presence event and a falling edge becomes an absence event. Each event is a one-cycle pulse with a direction bit. A failed configuration or a missing ready signal leaves the block in an error state with a code. From detection or error, a new request with new settings restarts the whole power cycle. After reset the block runs one bring-up with the default settings: threshold 56, gain 2, filter type B.

Top module: `pir_bringup_seq`

## Requirements
- R1: After reset the supply enable, both line-drive enables, `detecting` and `evt_valid` are low, and `err_code` is 0. The settings outputs hold the defaults: threshold 56, gain code 3 (gain 2) and filter code 0 (type B). A bring-up then starts on its own.
- R2: Each bring-up begins with `pwr_en` low for at least `T_OFF` cycles, after which `pwr_en` goes high.
- R3: Falling edges on `line_in` during the first `T_BLANK` cycles after the supply turns on are not counted as ready edges.
- R4: Readiness requires two falling edges after the blank period. A single edge never starts configuration.
- R5: `cfg_start` pulses once, no sooner than `T_GAP` cycles after the second ready edge. `line_oe` and `data_oe` are high only while a configuration is in progress, and only while the supply is on.
- R6: If the two ready edges do not arrive within `T_READY_MAX` cycles after the blank period, the block stops with `err_code` = 1 (encoding: 0 none, 1 ready timeout, 2 configuration failure).
- R7: When `cfg_done` arrives with `cfg_ok` high, `detecting` rises and both drive enables drop. When `cfg_done` arrives with `cfg_ok` low, `err_code` becomes 2 and `detecting` stays low.
- R8: In detection mode, a rising level on `line_in` gives one `evt_valid` pulse with `evt_dir` = 1, and a falling level gives one with `evt_dir` = 0. An unchanged level gives no event.
- R9: No event is reported in any state other than detection (supply off, blank, waiting, configuration or error).
- R10: `cfg_req` is accepted only in detection or error. In any other state it changes neither the settings nor the sequence.
- R11: A request whose gain value is 0 is ignored, even in detection or error.
- R12: Accepted settings are encoded as follows. Gain 1, 2, 3 gives code 1, 3, 0. Filter index 0, 1, 2, 3 (types A to D) gives code 7, 0, 1, 2. The threshold passes through unchanged. An accepted request also clears `err_code` and turns the supply off.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cfg_req | input | 1 | One-cycle request to reconfigure with new settings |
| req_thresh | input | TH_W | Requested detection threshold |
| req_gain | input | 2 | Requested gain value (1 to 3) |
| req_filter | input | 2 | Requested filter type index (0 = A to 3 = D) |
| line_in | input | 1 | Asynchronous shared clock/detect line from the sensor |
| cfg_done | input | 1 | Settings engine finished |
| cfg_ok | input | 1 | Settings engine result, valid with cfg_done |
| pwr_en | output | 1 | Sensor supply enable |
| line_oe | output | 1 | Clock/detect line is driven by the settings engine |
| data_oe | output | 1 | Data line is driven by the settings engine |
| cfg_start | output | 1 | One-cycle start to the settings engine |
| set_thresh | output | TH_W | Threshold field for the settings engine |
| set_gain_code | output | 2 | Encoded gain field |
| set_filt_code | output | 3 | Encoded filter field |
| detecting | output | 1 | Detection mode active |
| err_code | output | 2 | Error code |
| evt_valid | output | 1 | Detection event pulse |
| evt_dir | output | 1 | Event direction: 1 presence, 0 absence |

## Verification
The hardest situations to reach from the ports are the ones where edges on the line must be ignored. These are edges during the ramp-up blank, a lone ready edge, and edges while configuration or error holds the block. Each of them looks exactly like a valid edge in another state. The bench places falling edges inside the blank window and then delivers only one edge after it. It checks that configuration has not started. Only then does it deliver the second edge and time the start pulse against the gap. It also toggles the line while the supply is off, during configuration and in the error state, and confirms that the event counts do not move.

// File: rtl/pir_seq_pkg.sv
package pir_seq_pkg;

  typedef enum logic [2:0] {
    ST_OFF,
    ST_BLANK,
    ST_WAIT,
    ST_GAP,
    ST_CFG,
    ST_DET,
    ST_ERR
  } seq_state_t;

  typedef enum logic [1:0] {
    ERR_NONE    = 2'd0,
    ERR_TIMEOUT = 2'd1,
    ERR_CONFIG  = 2'd2
  } seq_err_t;

  // Power-up defaults: threshold 56, gain 2, filter type B, in encoded form.
  localparam int         DEF_THRESH    = 56;
  localparam logic [1:0] DEF_GAIN_CODE = 2'd3;
  localparam logic [2:0] DEF_FILT_CODE = 3'd0;

endpackage

// File: rtl/pir_line_sync.sv
module pir_line_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic line_async,
  output logic rise,
  output logic fall
);
  // STAGES flops of synchroniser plus one history flop for edge detection.
  logic [STAGES:0] sh;

  always_ff @(posedge clk) begin
    if (rst) sh <= '0;
    else     sh <= {sh[STAGES-1:0], line_async};
  end

  assign rise = sh[STAGES-1] & ~sh[STAGES];
  assign fall = ~sh[STAGES-1] & sh[STAGES];
endmodule

// File: rtl/pir_setting_enc.sv
module pir_setting_enc #(
  parameter int TH_W = 8
) (
  input  logic [TH_W-1:0] thresh_i,
  input  logic [1:0]      gain_val,
  input  logic [1:0]      filt_idx,
  output logic [TH_W-1:0] thresh_o,
  output logic [1:0]      gain_code,
  output logic [2:0]      filt_code,
  output logic            valid
);
  assign thresh_o = thresh_i;

  always_comb begin
    valid = 1'b1;
    case (gain_val)
      2'd1:    gain_code = 2'd1;
      2'd2:    gain_code = 2'd3;
      2'd3:    gain_code = 2'd0;
      default: begin gain_code = 2'd0; valid = 1'b0; end
    endcase
  end

  always_comb begin
    case (filt_idx)
      2'd0:    filt_code = 3'd7;
      2'd1:    filt_code = 3'd0;
      2'd2:    filt_code = 3'd1;
      default: filt_code = 3'd2;
    endcase
  end
endmodule

// File: rtl/pir_interval_timer.sv
module pir_interval_timer #(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         restart,
  input  logic [W-1:0] limit,
  output logic         expired
);
  logic [W-1:0] cnt;

  // Expires in the limit-th cycle after a restart; holds there.
  assign expired = (cnt >= limit - 1'b1);

  always_ff @(posedge clk) begin
    if (rst || restart) cnt <= '0;
    else if (!expired)  cnt <= cnt + 1'b1;
  end
endmodule

// File: rtl/pir_bringup_seq.sv
module pir_bringup_seq
  import pir_seq_pkg::*;
#(
  parameter int CLK_KHZ     = 125000,
  parameter int TH_W        = 8,
  parameter int READY_EDGES = 2,
  parameter int SYNC_STAGES = 2,
  parameter int T_OFF       = 35 * CLK_KHZ,
  parameter int T_BLANK     = 2 * CLK_KHZ,
  parameter int T_READY_MAX = 1300 * CLK_KHZ,
  parameter int T_GAP       = (CLK_KHZ + 99) / 100
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            cfg_req,
  input  logic [TH_W-1:0] req_thresh,
  input  logic [1:0]      req_gain,
  input  logic [1:0]      req_filter,
  input  logic            line_in,
  input  logic            cfg_done,
  input  logic            cfg_ok,
  output logic            pwr_en,
  output logic            line_oe,
  output logic            data_oe,
  output logic            cfg_start,
  output logic [TH_W-1:0] set_thresh,
  output logic [1:0]      set_gain_code,
  output logic [2:0]      set_filt_code,
  output logic            detecting,
  output logic [1:0]      err_code,
  output logic            evt_valid,
  output logic            evt_dir
);
  localparam int TMAX_A = (T_OFF > T_BLANK) ? T_OFF : T_BLANK;
  localparam int TMAX_B = (T_READY_MAX > T_GAP) ? T_READY_MAX : T_GAP;
  localparam int TMAX   = (TMAX_A > TMAX_B) ? TMAX_A : TMAX_B;
  localparam int TW     = $clog2(TMAX + 1);
  localparam int EW     = $clog2(READY_EDGES + 1);

  seq_state_t st, st_n;
  seq_err_t   err_q, err_n;
  logic [EW-1:0] fall_cnt;
  logic [TW-1:0] limit;
  logic expired, restart;
  logic rise, fall;

  logic [TH_W-1:0] enc_thresh;
  logic [1:0]      enc_gain;
  logic [2:0]      enc_filt;
  logic            enc_valid, accept;

  pir_line_sync #(.STAGES(SYNC_STAGES)) sync_i (
    .clk(clk), .rst(rst), .line_async(line_in), .rise(rise), .fall(fall)
  );

  pir_setting_enc #(.TH_W(TH_W)) enc_i (
    .thresh_i(req_thresh), .gain_val(req_gain), .filt_idx(req_filter),
    .thresh_o(enc_thresh), .gain_code(enc_gain), .filt_code(enc_filt),
    .valid(enc_valid)
  );

  pir_interval_timer #(.W(TW)) tmr_i (
    .clk(clk), .rst(rst), .restart(restart), .limit(limit), .expired(expired)
  );

  always_comb begin
    case (st)
      ST_OFF:   limit = TW'(T_OFF);
      ST_BLANK: limit = TW'(T_BLANK);
      ST_WAIT:  limit = TW'(T_READY_MAX);
      ST_GAP:   limit = TW'(T_GAP);
      default:  limit = TW'(1);
    endcase
  end

  assign accept  = cfg_req && enc_valid && (st == ST_DET || st == ST_ERR);
  assign restart = (st_n != st);

  always_comb begin
    st_n  = st;
    err_n = err_q;
    case (st)
      ST_OFF:   if (expired) st_n = ST_BLANK;
      ST_BLANK: if (expired) st_n = ST_WAIT;
      ST_WAIT: begin
        if (fall && fall_cnt == EW'(READY_EDGES - 1)) st_n = ST_GAP;
        else if (expired) begin
          st_n  = ST_ERR;
          err_n = ERR_TIMEOUT;
        end
      end
      ST_GAP:   if (expired) st_n = ST_CFG;
      ST_CFG: begin
        if (cfg_done) begin
          if (cfg_ok) st_n = ST_DET;
          else begin
            st_n  = ST_ERR;
            err_n = ERR_CONFIG;
          end
        end
      end
      default: begin
        if (accept) begin
          st_n  = ST_OFF;
          err_n = ERR_NONE;
        end
      end
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      st            <= ST_OFF;
      err_q         <= ERR_NONE;
      fall_cnt      <= '0;
      set_thresh    <= TH_W'(DEF_THRESH);
      set_gain_code <= DEF_GAIN_CODE;
      set_filt_code <= DEF_FILT_CODE;
      pwr_en        <= 1'b0;
      line_oe       <= 1'b0;
      data_oe       <= 1'b0;
      cfg_start     <= 1'b0;
      detecting     <= 1'b0;
      err_code      <= 2'd0;
      evt_valid     <= 1'b0;
      evt_dir       <= 1'b0;
    end else begin
      st    <= st_n;
      err_q <= err_n;
      if (restart)                 fall_cnt <= '0;
      else if (st == ST_WAIT && fall) fall_cnt <= fall_cnt + 1'b1;
      if (accept) begin
        set_thresh    <= enc_thresh;
        set_gain_code <= enc_gain;
        set_filt_code <= enc_filt;
      end
      pwr_en    <= (st_n != ST_OFF);
      line_oe   <= (st_n == ST_CFG);
      data_oe   <= (st_n == ST_CFG);
      cfg_start <= (st_n == ST_CFG) && (st != ST_CFG);
      detecting <= (st_n == ST_DET);
      err_code  <= err_n;
      evt_valid <= (st == ST_DET) && (st_n == ST_DET) && (rise || fall);
      evt_dir   <= rise;
    end
  end
endmodule

// File: rtl/pir_bringup_seq_chk.sv
module pir_bringup_seq_chk #(
  parameter int T_OFF = 1
) (
  input logic       clk,
  input logic       rst,
  input logic       pwr_en,
  input logic       line_oe,
  input logic       data_oe,
  input logic       cfg_start,
  input logic       cfg_done,
  input logic       cfg_ok,
  input logic       detecting,
  input logic       evt_valid,
  input logic [1:0] err_code
);
  logic [31:0] low_cnt;

  always_ff @(posedge clk) begin
    if (rst || pwr_en)          low_cnt <= '0;
    else if (low_cnt < T_OFF)   low_cnt <= low_cnt + 1;
  end

  // R1
  rst_quiet_chk: assert property (@(posedge clk) disable iff (rst)
    $past(rst) |-> (!pwr_en && !line_oe && !detecting));

  // R2
  off_window_chk: assert property (@(posedge clk) disable iff (rst)
    $rose(pwr_en) |-> (low_cnt >= T_OFF));

  // R5
  start_driven_chk: assert property (@(posedge clk) disable iff (rst)
    cfg_start |-> (line_oe && data_oe));

  // R5
  drive_powered_chk: assert property (@(posedge clk) disable iff (rst)
    line_oe |-> pwr_en);

  // R7
  det_entry_chk: assert property (@(posedge clk) disable iff (rst)
    $rose(detecting) |-> $past(cfg_done && cfg_ok));

  // R9
  evt_in_det_chk: assert property (@(posedge clk) disable iff (rst)
    evt_valid |-> detecting);

  // R6
  err_idle_chk: assert property (@(posedge clk) disable iff (rst)
    (err_code != 2'd0) |-> (!detecting && !line_oe));
endmodule

bind pir_bringup_seq pir_bringup_seq_chk #(.T_OFF(T_OFF)) chk_i (
  .clk(clk), .rst(rst), .pwr_en(pwr_en), .line_oe(line_oe),
  .data_oe(data_oe), .cfg_start(cfg_start), .cfg_done(cfg_done),
  .cfg_ok(cfg_ok), .detecting(detecting), .evt_valid(evt_valid),
  .err_code(err_code)
);

// File: tb/pir_bringup_seq_tb_top.sv
module pir_bringup_seq_tb_top;
  localparam int TB_OFF   = 40;
  localparam int TB_BLANK = 30;
  localparam int TB_RDY   = 200;
  localparam int TB_GAP   = 20;

  // Detection table: {line level, expected presence total, expected absence total}
  localparam int VEC[6][3] = '{
    '{1, 1, 0}, '{1, 1, 0}, '{0, 1, 1}, '{1, 2, 1}, '{0, 2, 2}, '{0, 2, 2}
  };

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic cfg_req = 1'b0;
  logic [7:0] req_thresh = '0;
  logic [1:0] req_gain = '0;
  logic [1:0] req_filter = '0;
  logic line_in = 1'b0;
  logic cfg_done = 1'b0;
  logic cfg_ok = 1'b0;
  logic pwr_en, line_oe, data_oe, cfg_start, detecting, evt_valid, evt_dir;
  logic [7:0] set_thresh;
  logic [1:0] set_gain_code, err_code;
  logic [2:0] set_filt_code;

  int n_chk = 0, n_bad = 0;
  int n_pres = 0, n_abs = 0, n_start = 0;
  bit done = 1'b0;

  always #4 clk = ~clk;

  pir_bringup_seq #(
    .T_OFF(TB_OFF), .T_BLANK(TB_BLANK), .T_READY_MAX(TB_RDY), .T_GAP(TB_GAP)
  ) dut_i (
    .clk(clk), .rst(rst), .cfg_req(cfg_req), .req_thresh(req_thresh),
    .req_gain(req_gain), .req_filter(req_filter), .line_in(line_in),
    .cfg_done(cfg_done), .cfg_ok(cfg_ok), .pwr_en(pwr_en), .line_oe(line_oe),
    .data_oe(data_oe), .cfg_start(cfg_start), .set_thresh(set_thresh),
    .set_gain_code(set_gain_code), .set_filt_code(set_filt_code),
    .detecting(detecting), .err_code(err_code), .evt_valid(evt_valid),
    .evt_dir(evt_dir)
  );

  always @(negedge clk) begin
    if (!rst) begin
      if (evt_valid) begin
        if (evt_dir) n_pres++;
        else         n_abs++;
      end
      if (cfg_start) n_start++;
    end
  end

  task automatic tick(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic chk(input string req, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic fall_edge();
    line_in = 1'b1; tick(3);
    line_in = 1'b0; tick(3);
  endtask

  task automatic request(input int th, input int g, input int f);
    req_thresh = 8'(th); req_gain = 2'(g); req_filter = 2'(f);
    cfg_req = 1'b1; tick(1); cfg_req = 1'b0;
  endtask

  task automatic wait_power();
    while (!pwr_en) tick(1);
  endtask

  task automatic summary();
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog: actual 1 expected 0");
      summary();
    end
  end

  initial begin
    tick(4);
    rst = 1'b0;
    tick(2);
    // R1 reset state and defaults
    chk("R1 pwr_en", pwr_en, 0);
    chk("R1 line_oe", line_oe, 0);
    chk("R1 detecting", detecting, 0);
    chk("R1 err_code", err_code, 0);
    chk("R1 thresh", set_thresh, 56);
    chk("R1 gain code", set_gain_code, 3);
    chk("R1 filt code", set_filt_code, 0);
    tick(33);
    chk("R2 supply still off", pwr_en, 0);
    tick(15);
    chk("R2 supply on", pwr_en, 1);
    // R3 edges inside the blank window
    fall_edge(); fall_edge();
    tick(20);
    // R4 a single ready edge
    fall_edge();
    tick(30);
    chk("R3 R4 no start", n_start, 0);
    chk("R4 not driving", line_oe, 0);
    fall_edge();
    chk("R5 gap honoured", n_start, 0);
    tick(40);
    chk("R5 one start", n_start, 1);
    chk("R5 line_oe", line_oe, 1);
    chk("R5 data_oe", data_oe, 1);
    // R9 toggles during configuration
    line_in = 1'b1; tick(3); line_in = 1'b0; tick(8);
    chk("R9 none in config", n_pres + n_abs, 0);
    cfg_done = 1'b1; cfg_ok = 1'b1; tick(1); cfg_done = 1'b0;
    tick(2);
    chk("R7 detecting", detecting, 1);
    chk("R7 released", line_oe + data_oe, 0);
    // R8 detection table
    for (int i = 0; i < 6; i++) begin
      line_in = VEC[i][0][0];
      tick(8);
      chk("R8 presence count", n_pres, VEC[i][1]);
      chk("R8 absence count", n_abs, VEC[i][2]);
    end
    // R12 request from detection
    request(200, 3, 3);
    tick(2);
    chk("R12 supply off", pwr_en, 0);
    chk("R12 left detect", detecting, 0);
    chk("R12 thresh", set_thresh, 200);
    chk("R12 gain 3 code", set_gain_code, 0);
    chk("R12 filter D code", set_filt_code, 2);
    line_in = 1'b1; tick(4); line_in = 1'b0; tick(4);
    chk("R9 none while off", n_pres + n_abs, 4);
    // R6 timeout without ready edges
    wait_power();
    tick(TB_BLANK + TB_RDY - 10);
    chk("R6 before timeout", err_code, 0);
    tick(20);
    chk("R6 timeout code", err_code, 1);
    chk("R6 not detecting", detecting, 0);
    line_in = 1'b1; tick(4); line_in = 1'b0; tick(4);
    chk("R9 none in error", n_pres + n_abs, 4);
    // R11 invalid gain
    request(77, 0, 2);
    tick(5);
    chk("R11 err kept", err_code, 1);
    chk("R11 supply kept", pwr_en, 1);
    chk("R11 thresh kept", set_thresh, 200);
    // R12 request from error
    request(0, 1, 0);
    tick(2);
    chk("R12 err cleared", err_code, 0);
    chk("R12 gain 1 code", set_gain_code, 1);
    chk("R12 filter A code", set_filt_code, 7);
    // R10 request while sequencing
    request(99, 2, 1);
    tick(2);
    chk("R10 thresh kept", set_thresh, 0);
    chk("R10 still off", pwr_en, 0);
    wait_power();
    tick(TB_BLANK + 5);
    fall_edge(); fall_edge();
    tick(40);
    chk("R10 single start", n_start, 2);
    chk("R10 settings kept", set_thresh, 0);
    // R7 failed configuration
    cfg_done = 1'b1; cfg_ok = 1'b0; tick(1); cfg_done = 1'b0;
    tick(2);
    chk("R7 config error", err_code, 2);
    chk("R7 no detect", detecting, 0);
    chk("R7 released", line_oe, 0);
    done = 1'b1;
    summary();
  end
endmodule